// File: doc/BRIEF.md
# Banked GPIO Controller with Event Interrupt

This block is a register-programmed general-purpose I/O controller. Its pins are split into several banks of 32 bit positions each, and each bank can implement fewer than 32 real pins. Per bank, eight 32-bit words set the output drive (push-pull or open-drain), the pin direction and the output data, and they configure event detection for each pin. A bank may also be left entirely empty. In that case it still takes its slot in the address space.

Each pin input passes through a two-flop synchronizer. The controller then watches the synchronized value for a rising edge, a falling edge, either edge, a high level or a low level, as the configuration selects for that pin. A detected event sets a sticky status bit, and software clears that bit by writing a one to it. Every status bit that is enabled by its mask bit feeds one shared interrupt line for the whole controller.

Software reaches the registers through a plain word-addressed port. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `gpio_multibank`

## Requirements
- R1: After a synchronous reset, every register reads 0, except the direction word, which reads all ones over the implemented pins (all pins are inputs). The interrupt output is 0.
- R2: The word address is bank*8 + index, with the bank in the upper bits. The index order is: 0 open-drain, 1 data, 2 direction, 3 polarity, 4 any-edge, 5 mask, 6 level, 7 status. Read data follows the address in the same cycle. A write to a bank number at or above the bank count changes nothing, and a read from such a bank returns 0.
- R3: A direction bit of 1 makes the pin an input, and a direction bit of 0 makes it an output. For an output pin with open-drain clear, the enable is 1 and the pin drives the data bit. For an output pin with open-drain set, data 0 drives low with enable 1, and data 1 releases the pin (enable 0). For an input pin, the enable and the pin value are both 0.
- R4: Reading the data word returns the synchronized pin value at input positions and the stored data bit at output positions. A change on a pin becomes visible in this read two clock edges after the change.
- R5: With level 0 and any-edge 0, polarity 1 detects rising edges and polarity 0 detects falling edges. The status bit is set on the third clock edge after the pin change.
- R6: With level 0 and any-edge 1, both edges set status, whatever the polarity bit holds.
- R7: With level 1, the pin is level-sensitive: polarity 1 means active high and polarity 0 means active low. Status is set again on every cycle that the active level persists, so a clear has no lasting effect while the level is still present.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear takes priority over the clear.
- R9: The interrupt output is 1 exactly when some bank has a status bit and its matching mask bit both set.
- R10: Bit positions at or above a bank's width, and every bit of an empty bank, always read 0. They never set status and never drive an enable or a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Word address (bank, index) |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pin_in | input | 96 | Raw pin levels, bank b at bits [32b+31:32b] |
| pin_oe | output | 96 | Pin output enables |
| pin_out | output | 96 | Pin output values |
| irq | output | 1 | Combined interrupt |

## Verification
Results arrive at different latencies. Register writes and pin drive settings take effect at the write edge. A pin change reaches the data read after two edges. It reaches status, and with it the interrupt, after three edges.

The bench keeps a behavioural model that uses the same edge counts. It compares the outputs and the read data every cycle, 1 ns after the rising edge. The directed checks read just before and just after each expected edge, so an extra or a missing pipeline stage shows up as a failure.

// File: rtl/gpio_mb_pkg.sv
`timescale 1ns/1ps
// Shared constants and register index encoding for the banked GPIO.
package gpio_mb_pkg;
    localparam int PINS_PER_BANK = 32;
    localparam int IDX_W         = 3;

    typedef logic [PINS_PER_BANK-1:0] pin_vec_t;

    typedef enum logic [IDX_W-1:0] {
        RI_OPEN_DRAIN = 3'd0,
        RI_DATA       = 3'd1,
        RI_DIR        = 3'd2,
        RI_POLARITY   = 3'd3,
        RI_ANY_EDGE   = 3'd4,
        RI_MASK       = 3'd5,
        RI_LEVEL      = 3'd6,
        RI_STATUS     = 3'd7
    } reg_idx_e;

    // Mask of implemented pin positions for a bank of the given width.
    function automatic pin_vec_t impl_mask(input int width);
        if (width >= PINS_PER_BANK) return '1;
        return pin_vec_t'((64'd1 << width) - 64'd1);
    endfunction
endpackage

// File: rtl/gpio_mb_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for asynchronous pin levels.
// Assumes the inputs are quasi-static relative to clk; no glitch filtering.
module gpio_mb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the raw pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/gpio_mb_detect.sv
`timescale 1ns/1ps
// Per-pin event detector: level or edge according to the configuration words.
// Assumes cur_i is already synchronized; keeps its own previous sample.
module gpio_mb_detect #(
    parameter int           W    = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] any_i,
    output logic [W-1:0] event_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise, fall, lvl_hit, edge_hit;

    // Hold last synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_i;
    end

    // Classify each bit as a level or edge event.
    always_comb begin
        rise     = cur_i & ~prev_q;
        fall     = ~cur_i & prev_q;
        lvl_hit  = ~(cur_i ^ pol_i);
        edge_hit = (any_i & (rise | fall)) | (~any_i & pol_i & rise) | (~any_i & ~pol_i & fall);
        event_o  = IMPL & ((level_i & lvl_hit) | (~level_i & edge_hit));
    end
endmodule

// File: rtl/gpio_mb_bank.sv
`timescale 1ns/1ps
// One bank: eight configuration/status words, pin drive, event latching.
// Assumes wr_en_i is already qualified by the bank decode; reads are combinational.
module gpio_mb_bank
    import gpio_mb_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  pin_vec_t         wdata_i,
    output pin_vec_t         rdata_o,
    input  pin_vec_t         pin_in_i,
    output pin_vec_t         pin_oe_o,
    output pin_vec_t         pin_out_o,
    output logic             irq_o
);
    localparam pin_vec_t IMPL = impl_mask(WIDTH);

    pin_vec_t od_q, data_q, dir_q, pol_q, any_q, mask_q, lvl_q, stat_q;
    pin_vec_t pin_sync, ev, clr;
    reg_idx_e idx;

    assign idx = reg_idx_e'(idx_i);

    gpio_mb_sync #(.W(PINS_PER_BANK)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in_i), .sync_o(pin_sync)
    );

    gpio_mb_detect #(.W(PINS_PER_BANK), .IMPL(IMPL)) det_i (
        .clk(clk), .rst_n(rst_n), .cur_i(pin_sync), .level_i(lvl_q),
        .pol_i(pol_q), .any_i(any_q), .event_o(ev)
    );

    // Configuration word writes, masked to implemented pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            od_q   <= '0;
            data_q <= '0;
            dir_q  <= IMPL;
            pol_q  <= '0;
            any_q  <= '0;
            mask_q <= '0;
            lvl_q  <= '0;
        end else if (wr_en_i) begin
            case (idx)
                RI_OPEN_DRAIN: od_q   <= wdata_i & IMPL;
                RI_DATA:       data_q <= wdata_i & IMPL;
                RI_DIR:        dir_q  <= wdata_i & IMPL;
                RI_POLARITY:   pol_q  <= wdata_i & IMPL;
                RI_ANY_EDGE:   any_q  <= wdata_i & IMPL;
                RI_MASK:       mask_q <= wdata_i & IMPL;
                RI_LEVEL:      lvl_q  <= wdata_i & IMPL;
                default:       ;
            endcase
        end
    end

    // Write-one-to-clear mask for the status word.
    assign clr = (wr_en_i && idx == RI_STATUS) ? wdata_i : '0;

    // Sticky status: new events win over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | ev;
    end

    // Pin drive: push-pull or open-drain outputs, inputs released.
    always_comb begin
        pin_oe_o  = IMPL & ~dir_q & ~(od_q & data_q);
        pin_out_o = IMPL & ~dir_q & ~od_q & data_q;
    end

    // Read-back mux of the addressed word.
    always_comb begin
        case (idx)
            RI_OPEN_DRAIN: rdata_o = od_q;
            RI_DATA:       rdata_o = IMPL & ((dir_q & pin_sync) | (~dir_q & data_q));
            RI_DIR:        rdata_o = dir_q;
            RI_POLARITY:   rdata_o = pol_q;
            RI_ANY_EDGE:   rdata_o = any_q;
            RI_MASK:       rdata_o = mask_q;
            RI_LEVEL:      rdata_o = lvl_q;
            default:       rdata_o = stat_q;
        endcase
    end

    assign irq_o = |(stat_q & mask_q);

    // R10
    impl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q | pin_oe_o | pin_out_o) & ~IMPL) == '0);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && idx == RI_STATUS) |=> ((stat_q & $past(wdata_i & ~ev)) == '0));

    // R5
    event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((stat_q & $past(ev)) == $past(ev)));

    // R3
    input_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe_o | pin_out_o) & dir_q) == '0);
endmodule

// File: rtl/gpio_multibank.sv
`timescale 1ns/1ps
// Banked GPIO controller top: address decode, read mux, shared interrupt.
// Assumes BANK_WIDTHS holds one 6-bit width per bank, bank 0 in the low field.
module gpio_multibank
    import gpio_mb_pkg::*;
#(
    parameter int                     NUM_BANKS   = 3,
    parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd12, 6'd0, 6'd32},
    localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W     = BANK_SEL_W + IDX_W,
    localparam int PIN_W      = NUM_BANKS * PINS_PER_BANK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pin_out,
    output logic              irq
);
    logic [BANK_SEL_W-1:0] bank_sel;
    logic [IDX_W-1:0]      idx;
    pin_vec_t              bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0]  bank_irq;

    assign bank_sel = reg_addr[ADDR_W-1:IDX_W];
    assign idx      = reg_addr[IDX_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_hit;
        assign wr_hit = reg_wen && (bank_sel == BANK_SEL_W'(b));

        gpio_mb_bank #(.WIDTH(int'(BANK_WIDTHS[b*6 +: 6]))) bank_i (
            .clk(clk),
            .rst_n(rst_n),
            .wr_en_i(wr_hit),
            .idx_i(idx),
            .wdata_i(reg_wdata),
            .rdata_o(bank_rd[b]),
            .pin_in_i(pin_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pin_oe_o(pin_oe[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pin_out_o(pin_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .irq_o(bank_irq[b])
        );
    end

    // Select the addressed bank's word; absent banks read zero.
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel == BANK_SEL_W'(b)) reg_rdata = bank_rd[b];
        end
    end

    assign irq = |bank_irq;
endmodule

// File: tb/gpio_multibank_tb_top.sv
`timescale 1ns/1ps
module gpio_multibank_tb_top;
    localparam int NB = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [95:0] pin_in = '0;
    logic [95:0] pin_oe, pin_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    gpio_multibank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
    );

    // Reference model state: words per bank, sync stages, previous sample.
    logic [31:0] m_reg [NB][8];
    logic [31:0] m_s1 [NB];
    logic [31:0] m_s2 [NB];
    logic [31:0] m_pv [NB];
    logic [31:0] m_ev [NB];
    logic [31:0] ev;

    function automatic logic [31:0] impl(input int b);
        case (b)
            0: return 32'hFFFF_FFFF;
            2: return 32'h0000_0FFF;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : ref_model
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                for (int r = 0; r < 8; r++) m_reg[b][r] = 32'h0;
                m_reg[b][2] = impl(b);
                m_s1[b] = 0; m_s2[b] = 0; m_pv[b] = 0;
            end
        end else begin
            for (int b = 0; b < NB; b++) begin
                ev = 0;
                for (int i = 0; i < 32; i++) begin
                    if (m_reg[b][6][i])      ev[i] = (m_s2[b][i] == m_reg[b][3][i]);
                    else if (m_reg[b][4][i]) ev[i] = (m_s2[b][i] != m_pv[b][i]);
                    else if (m_reg[b][3][i]) ev[i] = m_s2[b][i] && !m_pv[b][i];
                    else                     ev[i] = !m_s2[b][i] && m_pv[b][i];
                end
                m_ev[b] = ev & impl(b);
            end
            for (int b = 0; b < NB; b++) begin
                if (reg_wen && int'(reg_addr[4:3]) == b) begin
                    if (reg_addr[2:0] == 3'd7)
                        m_reg[b][7] = (m_reg[b][7] & ~reg_wdata) | m_ev[b];
                    else begin
                        m_reg[b][int'(reg_addr[2:0])] = reg_wdata & impl(b);
                        m_reg[b][7] = m_reg[b][7] | m_ev[b];
                    end
                end else begin
                    m_reg[b][7] = m_reg[b][7] | m_ev[b];
                end
                m_pv[b] = m_s2[b];
                m_s2[b] = m_s1[b];
                m_s1[b] = pin_in[b*32 +: 32];
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        int b;
        b = int'(a[4:3]);
        if (b >= NB) return 32'h0;
        if (a[2:0] == 3'd1)
            return impl(b) & ((m_reg[b][2] & m_s2[b]) | (~m_reg[b][2] & m_reg[b][1]));
        return m_reg[b][int'(a[2:0])];
    endfunction

    task automatic chk(input string tag, input string what, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the model, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (cmp_on) begin
            logic [95:0] eoe, eout;
            logic        eirq;
            string       tag;
            eirq = 1'b0;
            for (int b = 0; b < NB; b++) begin
                eoe[b*32 +: 32]  = impl(b) & ~m_reg[b][2] & ~(m_reg[b][0] & m_reg[b][1]);
                eout[b*32 +: 32] = impl(b) & ~m_reg[b][2] & ~m_reg[b][0] & m_reg[b][1];
                if ((m_reg[b][7] & m_reg[b][5]) != 0) eirq = 1'b1;
            end
            chk("R3", "pin_oe", pin_oe, eoe);
            chk("R3", "pin_out", pin_out, eout);
            chk("R9", "irq", {95'b0, irq}, {95'b0, eirq});
            tag = (reg_addr[2:0] == 3'd1) ? "R4" : (reg_addr[2:0] == 3'd7) ? "R5" : "R2";
            chk(tag, "reg_rdata", {64'b0, reg_rdata}, {64'b0, exp_rd(reg_addr)});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_addr = a; reg_wen = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, "read", {64'b0, reg_rdata}, {64'b0, exp});
    endtask

    task automatic irq_is(input string tag, input logic exp);
        #1;
        chk(tag, "irq", {95'b0, irq}, {95'b0, exp});
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        pin_in[64+4] = 1'b1;
        step(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        step(1);
        // R1 reset values
        rd("R1", 5'd2, 32'hFFFF_FFFF);
        rd("R1", 5'd10, 32'h0);
        rd("R1", 5'd18, 32'h0000_0FFF);
        rd("R1", 5'd7, 32'h0);
        irq_is("R1", 1'b0);

        // R2 addressing and invalid bank
        step(1);
        wr(5'd21, 32'h5);
        rd("R2", 5'd21, 32'h5);
        rd("R2", 5'd13, 32'h0);
        wr(5'd29, 32'h3);
        rd("R2", 5'd29, 32'h0);
        rd("R2", 5'd21, 32'h5);

        // R3 drive: bits 0..15 outputs, bits 0..3 open-drain
        step(1);
        wr(5'd2, 32'hFFFF_0000);
        wr(5'd1, 32'h0000_A5A5);
        wr(5'd0, 32'h0000_000F);
        #1;
        chk("R3", "oe bank0", {64'b0, pin_oe[31:0]}, {64'b0, 32'h0000_FFFA});
        chk("R3", "out bank0", {64'b0, pin_out[31:0]}, {64'b0, 32'h0000_A5A0});

        // R4 data readback with two-edge latency
        step(1);
        pin_in[31:0] = 32'hBEEF_1234;
        reg_addr = 5'd1;
        step(1);
        rd("R4", 5'd1, 32'h0000_A5A5);
        step(1);
        rd("R4", 5'd1, 32'hBEEF_A5A5);

        // bank2: pin0 rise, pin1 fall, pin2 any, pin3 level high, pin4 level low
        step(1);
        wr(5'd19, 32'h9);
        wr(5'd20, 32'h4);
        wr(5'd22, 32'h18);
        wr(5'd21, 32'h1F);
        step(4);
        rd("R5", 5'd23, 32'h0);
        irq_is("R9", 1'b0);

        // R5 rising, exact latency
        step(1);
        pin_in[64+0] = 1'b1;
        step(2);
        rd("R5", 5'd23, 32'h0);
        step(1);
        rd("R5", 5'd23, 32'h1);
        irq_is("R9", 1'b1);
        step(1);
        wr(5'd23, 32'h1);
        rd("R8", 5'd23, 32'h0);
        pin_in[64+0] = 1'b0;
        step(4);
        rd("R5", 5'd23, 32'h0);

        // R5 falling
        step(1);
        pin_in[64+1] = 1'b1;
        step(4);
        rd("R5", 5'd23, 32'h0);
        step(1);
        pin_in[64+1] = 1'b0;
        step(4);
        rd("R5", 5'd23, 32'h2);
        step(1);
        wr(5'd23, 32'h2);

        // R6 both edges
        pin_in[64+2] = 1'b1;
        step(4);
        rd("R6", 5'd23, 32'h4);
        step(1);
        wr(5'd23, 32'h4);
        pin_in[64+2] = 1'b0;
        step(4);
        rd("R6", 5'd23, 32'h4);
        step(1);
        wr(5'd23, 32'h4);

        // R7 level high persists through clear
        pin_in[64+3] = 1'b1;
        step(4);
        rd("R7", 5'd23, 32'h8);
        step(1);
        wr(5'd23, 32'h8);
        rd("R7", 5'd23, 32'h8);
        pin_in[64+3] = 1'b0;
        step(4);
        wr(5'd23, 32'h8);
        rd("R7", 5'd23, 32'h0);

        // R7 level low
        step(1);
        pin_in[64+4] = 1'b0;
        step(4);
        rd("R7", 5'd23, 32'h10);
        step(1);
        pin_in[64+4] = 1'b1;
        step(4);
        wr(5'd23, 32'h10);
        rd("R7", 5'd23, 32'h0);

        // R8 write of zero or other bits leaves status set
        step(1);
        pin_in[64+0] = 1'b1;
        step(4);
        wr(5'd23, 32'h0);
        rd("R8", 5'd23, 32'h1);
        step(1);
        wr(5'd23, 32'h2);
        rd("R8", 5'd23, 32'h1);

        // R9 masking and cross-bank interrupt
        step(1);
        wr(5'd21, 32'h0);
        irq_is("R9", 1'b0);
        step(1);
        wr(5'd21, 32'h1F);
        irq_is("R9", 1'b1);
        step(1);
        wr(5'd23, 32'h1);
        irq_is("R9", 1'b0);
        step(1);
        wr(5'd3, 32'h8000_0000);
        pin_in[31] = 1'b0;
        step(4);
        wr(5'd7, 32'hFFFF_FFFF);
        wr(5'd5, 32'h8000_0000);
        irq_is("R9", 1'b0);
        step(1);
        pin_in[31] = 1'b1;
        step(3);
        irq_is("R9", 1'b1);
        step(1);
        wr(5'd7, 32'h8000_0000);
        irq_is("R9", 1'b0);

        // R10 unimplemented and empty bank bits
        step(1);
        wr(5'd16, 32'hFFFF_FFFF);
        rd("R10", 5'd16, 32'h0000_0FFF);
        step(1);
        wr(5'd10, 32'hFFFF_FFFF);
        rd("R10", 5'd10, 32'h0);
        step(1);
        wr(5'd20, 32'hFFFF_FFFF);
        pin_in[64+20] = 1'b1;
        pin_in[32+5]  = 1'b1;
        step(4);
        rd("R10", 5'd23, 32'h0);
        rd("R10", 5'd15, 32'h0);
        #1;
        chk("R10", "oe bank2 upper", {84'b0, pin_oe[95:84]}, {84'b0, 12'h0});

        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule